// File: doc/BRIEF.md
# USB Serial Receive Bit Decoder

This block sits behind a clock-recovery stage on the receive side of a USB port. It gets one sampled line level each time the bit-clock enable pulses, plus an end-of-packet flag from a separate line-state detector. It turns those levels back into data:

- It undoes the NRZI line coding.
- It finds the synchronisation pattern that opens every packet.
- It removes the zero that the sender inserts after each run of six ones.
- It packs the remaining bits, least-significant bit first, into bytes. Each byte appears on a one-clock valid strobe, and the first byte after the synchronisation pattern (the packet identifier) carries a start-of-packet flag.

A run of seven ones cannot come from a correct sender. When it sees one, the block raises a one-clock error strobe, drops the packet and goes back to looking for a new synchronisation pattern. The end-of-packet flag also sends it back to hunting, and any bits already collected for an unfinished byte are thrown away.

Top module: `usb_rx_bitdec`

## Requirements
- R1: `line_in` = 1 is the J level and `line_in` = 0 is the K level. A sampled level equal to the previous sampled level decodes as 1, and a different level decodes as 0. After reset or end of packet, the previous level is taken to be J.
- R2: While hunting, at least SYNC_MIN_ZEROS decoded zeros in a row (default 5), followed by a decoded one, complete the synchronisation pattern. A shorter run of zeros before the one does not start a packet.
- R3: The first data bit kept after the synchronisation pattern is bit 0 of the first byte. Each byte is assembled least-significant bit first.
- R4: `byte_sop` is 1 together with the first byte of a packet and 0 for every later byte.
- R5: After RUN_LEN (default 6) consecutive decoded ones, a following decoded zero is discarded and is not stored. This also applies when the inserted zero is the last bit before end of packet.
- R6: The closing one of the synchronisation pattern counts as the first one of a run. A packet whose first five data bits are ones therefore has its sixth bit discarded as an inserted zero.
- R7: A decoded one in the position of the inserted zero raises `stuff_err` for exactly one clock. The partial byte is dropped, and no further byte is produced until a new synchronisation pattern arrives.
- R8: When `eop_in` is 1, the block returns to hunting. A partial byte is discarded and is never presented.
- R9: `byte_valid` is a one-clock pulse in the clock after the `bit_en` cycle that completes the byte. `byte_data` holds its value until the next byte is presented.
- R10: After synchronous reset, `byte_valid`, `byte_sop`, `stuff_err` and `byte_data` are all 0, and the block is hunting.
- R11: Changes on `line_in` while `bit_en` is 0 have no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable; `line_in` is sampled when this is 1 |
| line_in | input | 1 | Recovered line level, 1 = J, 0 = K |
| eop_in | input | 1 | End of packet seen by the line-state detector |
| byte_valid | output | 1 | One-clock strobe for a completed byte |
| byte_sop | output | 1 | Marks the first byte of a packet, valid with `byte_valid` |
| byte_data | output | 8 | Assembled byte, LSb received first |
| stuff_err | output | 1 | One-clock strobe on seven consecutive ones |

## Verification
The following are checked by assertions on every cycle:

- `byte_valid` never lasts two cycles.
- `byte_sop` never appears without `byte_valid`.
- `byte_data` stays stable between strobes.
- The ones-run counter never exceeds the stuffing limit, and it is loaded with one at SYNC.
- After an error or end of packet the block is back in the hunt state, with no byte produced.
- A byte is only ever produced from the receive state.

Some behaviours only the directed scenarios can show, because each depends on a whole encoded bit stream:

- the decoded byte values and their LSb-first order;
- the dropping of an inserted zero right after SYNC, and of one just before end of packet;
- the rejection of a too-short SYNC;
- the indifference to line changes between enables.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned BIT_IDX_W   = $clog2(BYTE_W);
    localparam logic        LINE_IDLE_J = 1'b1;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_RECV = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic stb;
        logic bit_val;
    } dec_bit_t;

    typedef struct packed {
        logic              valid;
        logic              sop;
        logic [BYTE_W-1:0] data;
    } rx_byte_t;

    // Equal levels mean a one, a change means a zero.
    function automatic logic nrzi_decode(input logic cur, input logic prev);
        return cur == prev;
    endfunction

endpackage

// File: rtl/usb_rx_nrzi.sv
module usb_rx_nrzi
    import usb_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_en,
    input  logic     line_in,
    input  logic     force_idle,
    output dec_bit_t dec_o
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst || force_idle) begin
            prev_q <= LINE_IDLE_J;
        end else if (bit_en) begin
            prev_q <= line_in;
        end
    end

    always_comb begin
        dec_o.stb     = bit_en & ~force_idle;
        dec_o.bit_val = nrzi_decode(line_in, prev_q);
    end

    // R1: the line is taken to be idle J after end of packet
    assert_idle_after_eop_R1: assert property (@(posedge clk) disable iff (rst)
        force_idle |=> (prev_q == LINE_IDLE_J));

endmodule

// File: rtl/usb_rx_sync_hunt.sv
module usb_rx_sync_hunt
    import usb_rx_pkg::*;
#(
    parameter int unsigned MIN_ZEROS = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     active,
    input  dec_bit_t dec_i,
    output logic     sync_hit
);

    localparam int unsigned CW = $clog2(MIN_ZEROS + 1);

    logic [CW-1:0] zcnt_q;
    logic          run_full;

    assign run_full = (zcnt_q == CW'(MIN_ZEROS));

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            zcnt_q <= '0;
        end else if (dec_i.stb) begin
            if (dec_i.bit_val) begin
                zcnt_q <= '0;
            end else if (!run_full) begin
                zcnt_q <= zcnt_q + 1'b1;
            end
        end
    end

    assign sync_hit = active & dec_i.stb & dec_i.bit_val & run_full;

    // R2: the zero counter never passes its saturation point
    assert_zero_run_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        zcnt_q <= CW'(MIN_ZEROS));

endmodule

// File: rtl/usb_rx_unstuff.sv
module usb_rx_unstuff
    import usb_rx_pkg::*;
#(
    parameter int unsigned RUN_LEN = 6
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     load_one,
    input  logic     active,
    input  dec_bit_t dec_i,
    output logic     keep,
    output logic     drop,
    output logic     err
);

    localparam int unsigned OW = $clog2(RUN_LEN + 1);

    logic [OW-1:0] ones_q;
    logic          at_limit;
    logic          take;

    assign at_limit = (ones_q == OW'(RUN_LEN));
    assign take     = active & dec_i.stb;
    assign keep     = take & ~at_limit;
    assign drop     = take &  at_limit & ~dec_i.bit_val;
    assign err      = take &  at_limit &  dec_i.bit_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_q <= '0;
        end else if (load_one) begin
            ones_q <= OW'(1);
        end else if (!active) begin
            ones_q <= '0;
        end else if (dec_i.stb) begin
            if (at_limit || !dec_i.bit_val) begin
                ones_q <= '0;
            end else begin
                ones_q <= ones_q + 1'b1;
            end
        end
    end

    // R5: the run of ones never grows past the stuffing limit
    assert_run_bounded_R5: assert property (@(posedge clk) disable iff (rst)
        ones_q <= OW'(RUN_LEN));

    // R6: the closing one of SYNC starts the run
    assert_sync_one_counts_R6: assert property (@(posedge clk) disable iff (rst)
        load_one |=> (ones_q == OW'(1)));

endmodule

// File: rtl/usb_rx_assemble.sv
module usb_rx_assemble
    import usb_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     abort,
    input  logic     keep,
    input  logic     bit_val,
    output rx_byte_t byte_o
);

    logic [BYTE_W-1:0]    sr_q;
    logic [BIT_IDX_W-1:0] cnt_q;
    logic                 first_q;
    logic [BYTE_W-1:0]    sr_next;

    assign sr_next = {bit_val, sr_q[BYTE_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q    <= '0;
            cnt_q   <= '0;
            first_q <= 1'b0;
            byte_o  <= '0;
        end else begin
            byte_o.valid <= 1'b0;
            byte_o.sop   <= 1'b0;
            if (start) begin
                cnt_q   <= '0;
                first_q <= 1'b1;
            end else if (abort) begin
                cnt_q <= '0;
            end else if (keep) begin
                sr_q  <= sr_next;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == BIT_IDX_W'(BYTE_W - 1)) begin
                    byte_o.data  <= sr_next;
                    byte_o.valid <= 1'b1;
                    byte_o.sop   <= first_q;
                    first_q      <= 1'b0;
                end
            end
        end
    end

    // R4: the start flag only ever comes with a byte
    assert_sop_with_valid_R4: assert property (@(posedge clk) disable iff (rst)
        byte_o.sop |-> byte_o.valid);

    // R9: the byte strobe lasts a single clock
    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        byte_o.valid |=> !byte_o.valid);

    // R9: the presented byte holds between strobes
    assert_data_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !byte_o.valid |-> $stable(byte_o.data));

endmodule

// File: rtl/usb_rx_bitdec.sv
module usb_rx_bitdec
    import usb_rx_pkg::*;
#(
    parameter int unsigned SYNC_MIN_ZEROS = 5,
    parameter int unsigned RUN_LEN        = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              line_in,
    input  logic              eop_in,
    output logic              byte_valid,
    output logic              byte_sop,
    output logic [BYTE_W-1:0] byte_data,
    output logic              stuff_err
);

    rx_state_e state_q;
    dec_bit_t  dec;
    rx_byte_t  asm_out;
    logic      hunt_act;
    logic      recv_act;
    logic      sync_hit;
    logic      keep;
    logic      drop;
    logic      err;
    logic      stuff_err_q;

    assign hunt_act = (state_q == ST_HUNT) & ~eop_in;
    assign recv_act = (state_q == ST_RECV) & ~eop_in;

    usb_rx_nrzi nrzi_i (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .line_in    (line_in),
        .force_idle (eop_in),
        .dec_o      (dec)
    );

    usb_rx_sync_hunt #(.MIN_ZEROS(SYNC_MIN_ZEROS)) hunt_i (
        .clk      (clk),
        .rst      (rst),
        .active   (hunt_act),
        .dec_i    (dec),
        .sync_hit (sync_hit)
    );

    usb_rx_unstuff #(.RUN_LEN(RUN_LEN)) unstuff_i (
        .clk      (clk),
        .rst      (rst),
        .load_one (sync_hit),
        .active   (recv_act),
        .dec_i    (dec),
        .keep     (keep),
        .drop     (drop),
        .err      (err)
    );

    usb_rx_assemble asm_i (
        .clk     (clk),
        .rst     (rst),
        .start   (sync_hit),
        .abort   (eop_in | err),
        .keep    (keep),
        .bit_val (dec.bit_val),
        .byte_o  (asm_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_HUNT;
            stuff_err_q <= 1'b0;
        end else begin
            stuff_err_q <= err;
            if (eop_in || err) begin
                state_q <= ST_HUNT;
            end else if (sync_hit) begin
                state_q <= ST_RECV;
            end
        end
    end

    assign byte_valid = asm_out.valid;
    assign byte_sop   = asm_out.sop;
    assign byte_data  = asm_out.data;
    assign stuff_err  = stuff_err_q;

    // R8: end of packet returns to hunting without producing a byte
    assert_eop_return_R8: assert property (@(posedge clk) disable iff (rst)
        eop_in |=> (state_q == ST_HUNT && !byte_valid));

    // R7: an error strobe always finds the block hunting
    assert_err_hunt_R7: assert property (@(posedge clk) disable iff (rst)
        stuff_err |-> (state_q == ST_HUNT && !byte_valid));

    // R3: bytes come only out of the receive state
    assert_byte_after_recv_R3: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> ($past(state_q) == ST_RECV));

    // R5: an inserted zero is never kept as data
    assert_drop_not_kept_R5: assert property (@(posedge clk) disable iff (rst)
        drop |=> !stuff_err);

endmodule

// File: tb/usb_rx_bitdec_tb_top.sv
module usb_rx_bitdec_tb_top;

    logic       clk     = 1'b0;
    logic       rst     = 1'b1;
    logic       bit_en  = 1'b0;
    logic       line_in = 1'b1;
    logic       eop_in  = 1'b0;
    logic       byte_valid;
    logic       byte_sop;
    logic [7:0] byte_data;
    logic       stuff_err;

    int   n_cmp = 0;
    int   n_bad = 0;
    logic lvl   = 1'b1;
    int   tx_ones = 0;
    bit   glitch  = 1'b0;

    logic [7:0] got_data [0:63];
    logic       got_sop  [0:63];
    int         got_n = 0;
    int         err_n = 0;

    always #4 clk = ~clk;

    usb_rx_bitdec dut_i (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .line_in    (line_in),
        .eop_in     (eop_in),
        .byte_valid (byte_valid),
        .byte_sop   (byte_sop),
        .byte_data  (byte_data),
        .stuff_err  (stuff_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_valid) begin
                if (got_n < 64) begin
                    got_data[got_n] = byte_data;
                    got_sop[got_n]  = byte_sop;
                end
                got_n = got_n + 1;
            end
            if (stuff_err) err_n = err_n + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One decoded bit on the line, four clocks per bit time
    task automatic send_dec(input logic b);
        if (!b) lvl = ~lvl;
        @(negedge clk);
        line_in = lvl;
        bit_en  = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        if (glitch) line_in = ~lvl;
        @(negedge clk);
        line_in = lvl;
        @(negedge clk);
    endtask

    task automatic send_sync();
        for (int i = 0; i < 7; i++) send_dec(1'b0);
        send_dec(1'b1);
        tx_ones = 1;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            send_dec(b[i]);
            tx_ones = b[i] ? tx_ones + 1 : 0;
            if (tx_ones == 6) begin
                send_dec(1'b0);
                tx_ones = 0;
            end
        end
    endtask

    task automatic send_eop();
        @(negedge clk);
        eop_in  = 1'b1;
        lvl     = 1'b1;
        line_in = 1'b1;
        @(negedge clk);
        eop_in = 1'b0;
        tx_ones = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic test_reset();
        chk("R10", "byte_valid after reset", int'(byte_valid), 0);
        chk("R10", "byte_sop after reset", int'(byte_sop), 0);
        chk("R10", "stuff_err after reset", int'(stuff_err), 0);
        chk("R10", "byte_data after reset", int'(byte_data), 0);
    endtask

    task automatic test_basic();
        int base = got_n;
        glitch = 1'b1;   // R11: line wiggles between enables
        send_sync();
        send_byte(8'hA5);
        send_byte(8'h3C);
        glitch = 1'b0;
        repeat (6) @(negedge clk);
        chk("R9", "byte held after packet", int'(byte_data), 'h3C);
        send_eop();
        chk("R3", "byte count basic", got_n - base, 2);
        chk("R3", "first byte LSb first", int'(got_data[base]), 'hA5);
        chk("R4", "sop on first byte", int'(got_sop[base]), 1);
        chk("R11", "second byte with glitches", int'(got_data[base+1]), 'h3C);
        chk("R4", "no sop on second byte", int'(got_sop[base+1]), 0);
        chk("R1", "no error on clean packet", err_n, 0);
    endtask

    task automatic test_sync_one_counts();
        int base = got_n;
        send_sync();
        send_byte(8'h1F);
        send_byte(8'h80);
        send_eop();
        chk("R6", "byte count after early stuff", got_n - base, 2);
        chk("R6", "stuffed zero after SYNC dropped", int'(got_data[base]), 'h1F);
        chk("R6", "following byte aligned", int'(got_data[base+1]), 'h80);
    endtask

    task automatic test_long_ones();
        int base = got_n;
        int e0 = err_n;
        send_sync();
        send_byte(8'hFF);
        send_byte(8'hFF);
        send_byte(8'h00);
        send_byte(8'hFC);   // ends in six ones: stuffed zero just before EOP
        send_eop();
        chk("R5", "byte count long ones", got_n - base, 4);
        chk("R5", "ones byte 0", int'(got_data[base]), 'hFF);
        chk("R5", "ones byte 1", int'(got_data[base+1]), 'hFF);
        chk("R5", "zero byte", int'(got_data[base+2]), 'h00);
        chk("R5", "stuff before EOP", int'(got_data[base+3]), 'hFC);
        chk("R5", "no error from final stuff", err_n - e0, 0);
        base = got_n;
        send_sync();
        send_byte(8'h69);
        send_eop();
        chk("R4", "next packet sop", int'(got_sop[base]), 1);
        chk("R3", "next packet data", int'(got_data[base]), 'h69);
    endtask

    task automatic test_stuff_error();
        int base = got_n;
        int e0 = err_n;
        send_sync();
        send_byte(8'h01);
        for (int i = 0; i < 7; i++) send_dec(1'b1);
        for (int i = 0; i < 9; i++) send_dec(1'b1);
        chk("R7", "single error pulse", err_n - e0, 1);
        chk("R7", "bytes before abandon", got_n - base, 1);
        send_eop();
        base = got_n;
        send_sync();
        send_byte(8'h4B);
        send_eop();
        chk("R7", "recovery after error", int'(got_data[base]), 'h4B);
    endtask

    task automatic test_eop_partial();
        int base = got_n;
        send_sync();
        send_byte(8'h55);
        send_dec(1'b1);
        send_dec(1'b0);
        send_dec(1'b1);
        send_dec(1'b1);
        send_eop();
        chk("R8", "partial byte dropped", got_n - base, 1);
        base = got_n;
        send_sync();
        send_byte(8'hD2);
        send_eop();
        chk("R8", "alignment restarts", int'(got_data[base]), 'hD2);
        chk("R4", "sop after restart", int'(got_sop[base]), 1);
    endtask

    task automatic test_short_sync();
        int base = got_n;
        for (int i = 0; i < 3; i++) send_dec(1'b0);
        send_dec(1'b1);
        send_byte(8'hAA);
        send_byte(8'h00);
        send_eop();
        chk("R2", "short SYNC ignored", got_n - base, 0);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_basic();
        test_sync_one_counts();
        test_long_ones();
        test_stuff_error();
        test_eop_partial();
        test_short_sync();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule